// File: doc/BRIEF.md
# Rectangle Copy and Fill Engine

This engine draws axis-aligned rectangles of 32-bit pixels into a linear frame-buffer memory that is reached through a single word-wide request/ready port. The host drives the command fields on the input pins and pulses `start`. The engine then either copies a source rectangle onto a destination rectangle or fills the destination with one colour. The mix code selects which operation runs.

Two direction bits let the host program the far corner of a rectangle instead of the near one. When a bit is clear, the programmed coordinate is the right or bottom edge. The walk then runs from that edge toward the origin, so an overlapping copy is safe when the direction is chosen against the shift. Pitch and base come either from per-operation fields or from shared defaults. Commands whose geometry would leave memory are rejected and write nothing. After a successful operation the engine reports the updated destination coordinates, so the next rectangle can be chained.

Top module: `blit_engine`

## Requirements
- R1: While reset is held, `busy`, `done`, `error`, `coord_we` and `mem_req` are all low.
- R2: Mix code 8'hCC copies. Mix code 8'hF0 fills with `brush`. Mix code 8'h00 fills with 32'hFF000000. Mix code 8'hFF fills with 32'hFFFFFFFF. Any other code is rejected.
- R3: With `ctrl[0]` (left-to-right) set, the start column is the programmed X. With it clear, the start column is `X + 1 - width`, taken modulo 2^16. The same rule applies to both source and destination.
- R4: With `ctrl[1]` (top-to-bottom) set, the start row is the programmed Y. With it clear, the start row is `Y + 1 - height`, taken modulo 2^16. The same rule applies to both source and destination.
- R5: With `ctrl[2]` set, the destination and source pitch and base fields are used. With it clear, `dflt_pitch` and `dflt_base` are used for both.
- R6: A command is rejected if any of the following holds: a start X or Y exceeds 0x3FFF; the base is at or beyond `MEM_BYTES`; `base + (startY + height) * pitch` is at or beyond `MEM_BYTES`; the pitch is zero or not a multiple of 4; width or height is zero. For a copy, these checks apply to the source as well. A rejected command makes no memory access and no coordinate writeback.
- R7: Only datatype code 4'h6 (32 bits per pixel) is accepted. Any other code is rejected as in R6.
- R8: After a copy, the new destination X is `startX + width` when left-to-right, else `startX`. The new destination Y is `startY + height` when top-to-bottom, else `startY`.
- R9: After a fill, the new destination Y follows the R8 rule. The new destination X equals the programmed destination X.
- R10: A copy walks columns and rows in the programmed directions and reads each pixel before writing it. When the directions are chosen against the overlap, the result equals reading the whole source before writing.
- R11: Pixel (x, y) sits at word `(base + y*pitch)/4 + x`. A request keeps `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ready`. A fill makes one write per pixel. A copy makes one read and one write per pixel.
- R12: `busy` rises the cycle after an accepted `start` and stays high until the cycle `done` pulses. `done` lasts one cycle. `coord_we` pulses with `done` only on success. `error` holds until the next start. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, sampled while idle |
| ctrl | input | 3 | [0] left-to-right, [1] top-to-bottom, [2] per-operation pitch/base |
| mix | input | 8 | Operation code |
| dtype | input | 4 | Pixel datatype code |
| dst_x | input | CRD_W | Programmed destination X |
| dst_y | input | CRD_W | Programmed destination Y |
| src_x | input | CRD_W | Programmed source X |
| src_y | input | CRD_W | Programmed source Y |
| width | input | CRD_W | Rectangle width in pixels |
| height | input | CRD_W | Rectangle height in rows |
| dst_pitch | input | PITCH_W | Destination row pitch in bytes |
| src_pitch | input | PITCH_W | Source row pitch in bytes |
| dflt_pitch | input | PITCH_W | Shared default pitch in bytes |
| dst_base | input | ADDR_W | Destination byte base |
| src_base | input | ADDR_W | Source byte base |
| dflt_base | input | ADDR_W | Shared default byte base |
| brush | input | PIX_W | Brush fill colour |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Write enable of the request |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_wdata | output | PIX_W | Write data |
| mem_rdata | input | PIX_W | Read data, valid with mem_ready |
| mem_ready | input | 1 | Request accepted this cycle |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last command was rejected |
| coord_we | output | 1 | New destination coordinates valid |
| new_dst_x | output | CRD_W | Updated destination X |
| new_dst_y | output | CRD_W | Updated destination Y |

## Verification
The handshake assertion assumes that the memory returns read data in the same cycle as `mem_ready`, and that it never withdraws a pending request on its own. The bench memory model answers combinationally and gates `mem_ready` with a pseudo-random stall pattern that changes only between clock edges. The bounds check covers rows only. The engine therefore assumes that `startX + width` fits within the pitch, and every rectangle in the stimulus stays inside its row. The fields are held steady while `start` is sampled; the one test that changes them mid-command relies on R12 to ignore the change.

// File: rtl/blit_engine.sv
module blit_engine #(
  parameter int         CRD_W     = 16,
  parameter int         PITCH_W   = 16,
  parameter int         ADDR_W    = 16,
  parameter int         PIX_W     = 32,
  parameter int         MEM_BYTES = 8192,
  parameter int         COORD_LIM = 'h3FFF,
  parameter logic [3:0] DT_32BPP  = 4'h6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [2:0]         ctrl,
  input  logic [7:0]         mix,
  input  logic [3:0]         dtype,
  input  logic [CRD_W-1:0]   dst_x,
  input  logic [CRD_W-1:0]   dst_y,
  input  logic [CRD_W-1:0]   src_x,
  input  logic [CRD_W-1:0]   src_y,
  input  logic [CRD_W-1:0]   width,
  input  logic [CRD_W-1:0]   height,
  input  logic [PITCH_W-1:0] dst_pitch,
  input  logic [PITCH_W-1:0] src_pitch,
  input  logic [PITCH_W-1:0] dflt_pitch,
  input  logic [ADDR_W-1:0]  dst_base,
  input  logic [ADDR_W-1:0]  src_base,
  input  logic [ADDR_W-1:0]  dflt_base,
  input  logic [PIX_W-1:0]   brush,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-3:0]  mem_addr,
  output logic [PIX_W-1:0]   mem_wdata,
  input  logic [PIX_W-1:0]   mem_rdata,
  input  logic               mem_ready,
  output logic               busy,
  output logic               done,
  output logic               error,
  output logic               coord_we,
  output logic [CRD_W-1:0]   new_dst_x,
  output logic [CRD_W-1:0]   new_dst_y
);

  localparam int WA_W  = ADDR_W - 2;
  localparam int CHK_W = CRD_W + PITCH_W + ADDR_W + 2;
  localparam logic [CHK_W-1:0] MEM_END = CHK_W'(MEM_BYTES);
  localparam logic [CRD_W-1:0] LIM     = CRD_W'(COORD_LIM);
  localparam logic [7:0] OP_COPY  = 8'hCC;
  localparam logic [7:0] OP_BRUSH = 8'hF0;
  localparam logic [7:0] OP_BLACK = 8'h00;
  localparam logic [7:0] OP_WHITE = 8'hFF;

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_READ, S_WRITE} state_t;
  state_t st;

  logic [2:0]         r_ctrl;
  logic [7:0]         r_mix;
  logic [3:0]         r_dtype;
  logic [CRD_W-1:0]   r_dx, r_dy, r_sx, r_sy, r_w, r_h;
  logic [PITCH_W-1:0] r_dp, r_sp;
  logic [ADDR_W-1:0]  r_db, r_sb;
  logic [PIX_W-1:0]   r_brush, pix;

  logic [WA_W-1:0]    d_row, s_row, d_col, s_col, d_col0, s_col0;
  logic [WA_W-1:0]    d_pw, s_pw;
  logic [CRD_W-1:0]   col_cnt, row_cnt;

  function automatic logic region_ok(input logic [CRD_W-1:0] x, input logic [CRD_W-1:0] y,
                                     input logic [CRD_W-1:0] h, input logic [PITCH_W-1:0] p,
                                     input logic [ADDR_W-1:0] b);
    logic [CHK_W-1:0] last;
    last = CHK_W'(b) + (CHK_W'(y) + CHK_W'(h)) * CHK_W'(p);
    return (x <= LIM) && (y <= LIM) && (p != '0) && (p[1:0] == 2'b00)
           && (CHK_W'(b) < MEM_END) && (last < MEM_END);
  endfunction

  function automatic logic [WA_W-1:0] row_word(input logic [ADDR_W-1:0] b,
                                              input logic [CRD_W-1:0] y,
                                              input logic [PITCH_W-1:0] p);
    logic [CHK_W-1:0] a;
    a = CHK_W'(b) + CHK_W'(y) * CHK_W'(p);
    return a[WA_W+1:2];
  endfunction

  logic ltr, ttb, is_copy, rop_ok, cmd_ok, col_last, row_last;
  logic [CRD_W-1:0] dsx, dsy, ssx, ssy, dx0, dy0, sx0, sy0, wbx, wby;
  logic [PIX_W-1:0] fill_col;

  assign ltr = r_ctrl[0];
  assign ttb = r_ctrl[1];

  assign dsx = ltr ? r_dx : r_dx + CRD_W'(1) - r_w;
  assign dsy = ttb ? r_dy : r_dy + CRD_W'(1) - r_h;
  assign ssx = ltr ? r_sx : r_sx + CRD_W'(1) - r_w;
  assign ssy = ttb ? r_sy : r_sy + CRD_W'(1) - r_h;

  assign dx0 = ltr ? dsx : r_dx;
  assign dy0 = ttb ? dsy : r_dy;
  assign sx0 = ltr ? ssx : r_sx;
  assign sy0 = ttb ? ssy : r_sy;

  assign is_copy = (r_mix == OP_COPY);
  assign rop_ok  = is_copy || r_mix == OP_BRUSH || r_mix == OP_BLACK || r_mix == OP_WHITE;
  assign cmd_ok  = rop_ok && (r_dtype == DT_32BPP) && (r_w != '0) && (r_h != '0)
                   && region_ok(dsx, dsy, r_h, r_dp, r_db)
                   && (!is_copy || region_ok(ssx, ssy, r_h, r_sp, r_sb));

  assign fill_col = (r_mix == OP_BRUSH) ? r_brush :
                    (r_mix == OP_BLACK) ? {8'hFF, (PIX_W-8)'(0)} : '1;

  assign wbx = !is_copy ? r_dx : (ltr ? dsx + r_w : dsx);
  assign wby = ttb ? dsy + r_h : dsy;

  assign col_last = (col_cnt == r_w - CRD_W'(1));
  assign row_last = (row_cnt == r_h - CRD_W'(1));

  assign busy      = (st != S_IDLE);
  assign mem_req   = (st == S_READ) || (st == S_WRITE);
  assign mem_we    = (st == S_WRITE);
  assign mem_addr  = (st == S_READ) ? s_row + s_col : d_row + d_col;
  assign mem_wdata = is_copy ? pix : fill_col;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      done <= 1'b0;
      error <= 1'b0;
      coord_we <= 1'b0;
      new_dst_x <= '0;
      new_dst_y <= '0;
      r_ctrl <= '0;
      r_mix <= '0;
      r_dtype <= '0;
      r_dx <= '0;
      r_dy <= '0;
      r_sx <= '0;
      r_sy <= '0;
      r_w <= '0;
      r_h <= '0;
      r_dp <= '0;
      r_sp <= '0;
      r_db <= '0;
      r_sb <= '0;
      r_brush <= '0;
      pix <= '0;
      d_row <= '0;
      s_row <= '0;
      d_col <= '0;
      s_col <= '0;
      d_col0 <= '0;
      s_col0 <= '0;
      d_pw <= '0;
      s_pw <= '0;
      col_cnt <= '0;
      row_cnt <= '0;
    end else begin
      done <= 1'b0;
      coord_we <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          r_ctrl <= ctrl;
          r_mix <= mix;
          r_dtype <= dtype;
          r_dx <= dst_x;
          r_dy <= dst_y;
          r_sx <= src_x;
          r_sy <= src_y;
          r_w <= width;
          r_h <= height;
          r_dp <= ctrl[2] ? dst_pitch : dflt_pitch;
          r_sp <= ctrl[2] ? src_pitch : dflt_pitch;
          r_db <= ctrl[2] ? dst_base : dflt_base;
          r_sb <= ctrl[2] ? src_base : dflt_base;
          r_brush <= brush;
          error <= 1'b0;
          st <= S_CHECK;
        end
        S_CHECK: begin
          if (!cmd_ok) begin
            error <= 1'b1;
            done <= 1'b1;
            st <= S_IDLE;
          end else begin
            d_row <= row_word(r_db, dy0, r_dp);
            s_row <= row_word(r_sb, sy0, r_sp);
            d_col <= WA_W'(dx0);
            s_col <= WA_W'(sx0);
            d_col0 <= WA_W'(dx0);
            s_col0 <= WA_W'(sx0);
            d_pw <= WA_W'(r_dp >> 2);
            s_pw <= WA_W'(r_sp >> 2);
            col_cnt <= '0;
            row_cnt <= '0;
            st <= is_copy ? S_READ : S_WRITE;
          end
        end
        S_READ: if (mem_ready) begin
          pix <= mem_rdata;
          st <= S_WRITE;
        end
        S_WRITE: if (mem_ready) begin
          if (col_last && row_last) begin
            done <= 1'b1;
            coord_we <= 1'b1;
            new_dst_x <= wbx;
            new_dst_y <= wby;
            st <= S_IDLE;
          end else begin
            if (col_last) begin
              col_cnt <= '0;
              row_cnt <= row_cnt + CRD_W'(1);
              d_col <= d_col0;
              s_col <= s_col0;
              d_row <= ttb ? d_row + d_pw : d_row - d_pw;
              s_row <= ttb ? s_row + s_pw : s_row - s_pw;
            end else begin
              col_cnt <= col_cnt + CRD_W'(1);
              d_col <= ltr ? d_col + WA_W'(1) : d_col - WA_W'(1);
              s_col <= ltr ? s_col + WA_W'(1) : s_col - WA_W'(1);
            end
            st <= is_copy ? S_READ : S_WRITE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r11_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r12_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r12_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r6_reject_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    done && error |-> !coord_we);

  a_r8_writeback_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    coord_we |-> done);

  a_r2_fill_only_writes: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && (r_mix != OP_COPY) |-> mem_we);

endmodule

// File: tb/blit_engine_tb.sv
`timescale 1ns/1ps
module blit_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        start = 1'b0;
  logic [2:0]  ctrl;
  logic [7:0]  mix;
  logic [3:0]  dtype;
  logic [15:0] dx, dy, sx, sy, w, h, dpitch, spitch, dfpitch, dbase, sbase, dfbase;
  logic [31:0] brush;
  logic        mem_req, mem_we, mem_ready, busy, done, error, coord_we;
  logic [13:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [15:0] new_dst_x, new_dst_y;

  blit_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl(ctrl), .mix(mix), .dtype(dtype),
    .dst_x(dx), .dst_y(dy), .src_x(sx), .src_y(sy), .width(w), .height(h),
    .dst_pitch(dpitch), .src_pitch(spitch), .dflt_pitch(dfpitch),
    .dst_base(dbase), .src_base(sbase), .dflt_base(dfbase), .brush(brush),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .busy(busy), .done(done),
    .error(error), .coord_we(coord_we), .new_dst_x(new_dst_x), .new_dst_y(new_dst_y));

  logic [31:0] mem [0:2047];
  logic [31:0] exp_mem [0:2047];
  logic [7:0]  lfsr = 8'h5A;
  bit          stall_en = 1'b1;
  int          wr_cnt = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;

  always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  assign mem_ready = !stall_en || lfsr[0];
  assign mem_rdata = mem[mem_addr[10:0]];

  always @(posedge clk)
    if (mem_req && mem_we && mem_ready) begin
      mem[mem_addr[10:0]] <= mem_wdata;
      wr_cnt++;
    end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic defaults();
    ctrl = 3'b111; mix = 8'hF0; dtype = 4'h6;
    dx = 0; dy = 0; sx = 0; sy = 0; w = 1; h = 1;
    dpitch = 64; spitch = 64; dfpitch = 32;
    dbase = 0; sbase = 2048; dfbase = 4096; brush = 32'h0;
  endtask

  task automatic model();
    logic [15:0] xs, ys, xd, yd;
    int bd, bs, pd, ps, n;
    logic [31:0] col;
    logic [31:0] tmp [0:1023];
    bd = ctrl[2] ? int'(dbase) : int'(dfbase);
    bs = ctrl[2] ? int'(sbase) : int'(dfbase);
    pd = ctrl[2] ? int'(dpitch) : int'(dfpitch);
    ps = ctrl[2] ? int'(spitch) : int'(dfpitch);
    xd = ctrl[0] ? dx : dx + 16'd1 - w;
    yd = ctrl[1] ? dy : dy + 16'd1 - h;
    xs = ctrl[0] ? sx : sx + 16'd1 - w;
    ys = ctrl[1] ? sy : sy + 16'd1 - h;
    col = (mix == 8'hF0) ? brush : (mix == 8'h00) ? 32'hFF000000 : 32'hFFFFFFFF;
    n = 0;
    if (mix == 8'hCC)
      for (int r = 0; r < int'(h); r++)
        for (int c = 0; c < int'(w); c++) begin
          tmp[n] = exp_mem[(bs + (int'(ys) + r) * ps + (int'(xs) + c) * 4) / 4];
          n++;
        end
    n = 0;
    for (int r = 0; r < int'(h); r++)
      for (int c = 0; c < int'(w); c++) begin
        exp_mem[(bd + (int'(yd) + r) * pd + (int'(xd) + c) * 4) / 4] = (mix == 8'hCC) ? tmp[n] : col;
        n++;
      end
  endtask

  task automatic check_mem(input string req);
    int bad, first;
    bad = 0; first = -1;
    for (int i = 0; i < 2048; i++)
      if (mem[i] !== exp_mem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    if (first < 0) chk(1'b1, req, "memory", 0, 0);
    else chk(1'b0, req, $sformatf("memory word %0d", first), mem[first], exp_mem[first]);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    bit ok;
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    if (!ok) chk(1'b0, req, "done timeout", 0, 1);
  endtask

  task automatic good_cmd(input string req, input logic [15:0] wx, input logic [15:0] wy);
    model();
    pulse_start();
    wait_done(req);
    chk(error == 1'b0, req, "error flag", 32'(error), 0);
    chk(coord_we == 1'b1, req, "coord_we", 32'(coord_we), 1);
    chk(new_dst_x == wx, req, "new_dst_x", 32'(new_dst_x), 32'(wx));
    chk(new_dst_y == wy, req, "new_dst_y", 32'(new_dst_y), 32'(wy));
    @(negedge clk);
    check_mem(req);
  endtask

  task automatic reject_cmd(input string req, input string what);
    int w0;
    w0 = wr_cnt;
    pulse_start();
    wait_done(req);
    chk(error == 1'b1, req, {what, " error"}, 32'(error), 1);
    chk(coord_we == 1'b0, req, {what, " no writeback"}, 32'(coord_we), 0);
    @(negedge clk);
    chk(wr_cnt == w0, req, {what, " no writes"}, 32'(wr_cnt - w0), 0);
    check_mem(req);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !error && !coord_we && !mem_req, "R1", "reset outputs",
        {27'd0, busy, done, error, coord_we, mem_req}, 0);
  endtask

  task automatic t_brush_fill();
    defaults(); mix = 8'hF0; brush = 32'h12345678;
    dx = 2; dy = 3; w = 4; h = 3; dbase = 256;
    good_cmd("R2_R9_brush", 16'd2, 16'd6);
  endtask

  task automatic t_black_far_corner();
    defaults(); mix = 8'h00; ctrl = 3'b100;
    dx = 5; dy = 4; w = 4; h = 2;
    good_cmd("R3_R4_R9_black", 16'd5, 16'd3);
  endtask

  task automatic t_white_default();
    defaults(); mix = 8'hFF; ctrl = 3'b011; dpitch = 0; dbase = 16'hFFFF;
    dx = 1; dy = 2; w = 3; h = 2;
    good_cmd("R5_R2_white", 16'd1, 16'd4);
  endtask

  task automatic t_copy_fwd();
    defaults(); mix = 8'hCC;
    sx = 1; sy = 1; dx = 6; dy = 10; w = 5; h = 4;
    good_cmd("R8_R11_copy", 16'd11, 16'd14);
  endtask

  task automatic t_copy_overlap_x();
    defaults(); mix = 8'hCC; ctrl = 3'b110; sbase = 0;
    sx = 9; dx = 11; sy = 20; dy = 20; w = 8; h = 3;
    good_cmd("R10_R3_overlap_x", 16'd4, 16'd23);
  endtask

  task automatic t_copy_overlap_y();
    defaults(); mix = 8'hCC; ctrl = 3'b101; sbase = 0;
    sx = 3; dx = 3; sy = 33; dy = 35; w = 3; h = 4;
    good_cmd("R10_R4_overlap_y", 16'd6, 16'd32);
  endtask

  task automatic t_rejects();
    defaults(); mix = 8'h66; dx = 1; dy = 1; w = 2; h = 2;
    reject_cmd("R2", "bad mix");
    defaults(); dtype = 4'h3; w = 2; h = 2;
    reject_cmd("R7", "bad datatype");
    defaults(); ctrl = 3'b110; dx = 1; w = 4; h = 1;
    reject_cmd("R6", "x underflow");
    defaults(); dy = 16'h4000; w = 1; h = 1;
    reject_cmd("R6", "y over limit");
    defaults(); dpitch = 0; w = 2; h = 2;
    reject_cmd("R6", "zero pitch");
    defaults(); dpitch = 62; w = 2; h = 2;
    reject_cmd("R6", "odd pitch");
    defaults(); dbase = 8192; w = 1; h = 1;
    reject_cmd("R6", "base beyond");
    defaults(); dy = 125; w = 2; h = 3;
    reject_cmd("R6", "rows past end");
    defaults(); mix = 8'hCC; spitch = 0; w = 2; h = 2;
    reject_cmd("R6", "source pitch");
    defaults(); w = 0; h = 2;
    reject_cmd("R6", "zero width");
  endtask

  task automatic t_error_clears_boundary();
    chk(error == 1'b1, "R12", "error held", 32'(error), 1);
    defaults(); brush = 32'h0BADF00D; dx = 0; dy = 125; w = 2; h = 2;
    good_cmd("R6_R12_boundary", 16'd0, 16'd127);
  endtask

  task automatic t_start_while_busy();
    int extra;
    defaults(); brush = 32'hCAFEF00D; dx = 0; dy = 60; w = 8; h = 8;
    model();
    pulse_start();
    repeat (5) @(negedge clk);
    chk(busy == 1'b1, "R12", "busy during fill", 32'(busy), 1);
    mix = 8'hFF; dy = 70; w = 2; h = 2;
    pulse_start();
    wait_done("R12");
    @(negedge clk);
    extra = 0;
    for (int i = 0; i < 20; i++) begin
      if (done || busy) extra++;
      @(negedge clk);
    end
    chk(extra == 0, "R12", "second start ignored", 32'(extra), 0);
    check_mem("R12");
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) begin
      mem[i] = 32'hA0000000 + 32'(i);
      exp_mem[i] = 32'hA0000000 + 32'(i);
    end
    defaults();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_brush_fill();
    t_black_far_corner();
    t_white_default();
    t_copy_fwd();
    t_copy_overlap_x();
    t_copy_overlap_y();
    t_rejects();
    t_error_clears_boundary();
    t_start_while_busy();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R12 watchdog actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule